// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is a slave-only port on a two-wire serial control bus. An external controller uses it to write or read single 16-bit registers in a local register bank. The block runs on a system clock. It samples the serial clock and data lines through synchronisers and answers only by pulling the data line low. The line is released for every logic 1, and an external pull-up restores the high level.

A transfer opens with a start condition and a device-ID byte. The block answers one of two IDs, chosen by a strap input. A write sends the ID with the direction bit clear, then a register address, then the high and low data bytes. Each byte is acknowledged, and a one-cycle write strobe goes to the bank after the last acknowledge. A read sends the ID and address the same way, then a repeated start and the ID with the direction bit set. The block then shifts out the addressed register, high byte first. A stop, or any start or stop that arrives out of sequence, returns the block to idle.

Top module: `twi_reg_slave`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the data-line pull is off and the write strobe is low. A reset that arrives while the block is acknowledging releases the line at once.
- R2: The block never drives a high level. A transmitted 1 appears as the pull released, and a transmitted 0 appears as the pull active.
- R3: With the strap low, an ID byte of 0x34 after a start is acknowledged. With the strap high, 0x36 is acknowledged. An acknowledge holds the pull active from the end of the eighth clock to the end of the ninth.
- R4: An ID byte that does not match the strap-selected value gets no acknowledge. The block then ignores the rest of the transfer: no pull and no write strobe until a new start.
- R5: A direction bit (bit 0 of the ID byte, 1 = read, 0 = write) that is wrong for the step is not acknowledged and sends the block to idle. This covers a set bit in the first ID byte and a clear bit in the ID byte that follows a repeated start.
- R6: A write consists of the ID, an address byte, a high data byte and a low data byte, each acknowledged. Once the last acknowledge clock ends, the write strobe is high for exactly one system cycle. At that cycle the address output carries the address byte and the write-data output carries {high, low}.
- R7: A read consists of the ID (write), the address, a repeated start and the ID (read), each acknowledged. The block then sends the register at that address MSB first, the high byte and then the low byte. It releases the line after the controller's not-acknowledge on the low byte.
- R8: A stop received before the low data byte is acknowledged ends the transfer with no write strobe, and the register keeps its old value.
- R9: A start detected in the middle of a byte aborts the transfer to idle. The ID byte that follows that start is not acknowledged.
- R10: The pull changes only while the synchronised serial clock is low, so it is steady through every high phase of the clock.
- R11: After a complete write or read, the block is idle and serves the next transfer that opens with a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Data line as seen on the bus |
| sda_pull_o | output | 1 | When high, the data line is pulled low (open-drain enable) |
| strap_sel_i | input | 1 | ID select strap: 0 selects 0x34, 1 selects 0x36 |
| reg_addr_o | output | 8 | Register address for the bank |
| reg_wdata_o | output | 16 | Register write data |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 16 | Read data of the addressed register |

## Verification
The assertions assume a bus with well-formed timing. Each serial-clock phase lasts many system cycles, so the synchronised clock cannot toggle again before a pull update takes effect. The data line is a wired AND, so a stop cannot be detected while the block pulls the line low. The bench keeps within this. It holds each serial-clock phase for twelve system cycles and changes its own data level only while the clock is low, except where it forms a start or stop on purpose. It computes the line as its own drive ANDed with the inverse of the pull. It also holds the strap constant during each transfer.

// File: rtl/twi_pkg.sv
package twi_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_ACK,
    S_TX,
    S_MACK
  } fsm_t;

  typedef enum logic [1:0] {
    G_ID,
    G_ADDR,
    G_DATA,
    G_RID
  } stage_t;

  // Full ID byte: upper six address bits, strap in bit 1, direction in bit 0
  function automatic logic [BYTE_W-1:0] dev_id_byte(input logic [6:0] dev7,
                                                    input logic strap,
                                                    input logic rw);
    return {dev7[6:1], strap, rw};
  endfunction

endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int          W      = 2,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic ev_start,
  output logic ev_stop
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  // Data edges qualify as conditions only while the clock stays high
  assign ev_start = scl_s & scl_q & sda_q & ~sda_s;
  assign ev_stop  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave
  import twi_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h1A,
  parameter int         DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic              strap_sel_i,
  output logic [BYTE_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);

  localparam int NB     = DATA_W / BYTE_W;
  localparam int BIDX_W = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [BIDX_W-1:0] LAST_B = BIDX_W'(NB - 1);

  // Synchronised bus and named events
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, ev_start, ev_stop;
  logic in_idle;

  twi_sync #(.W(2), .STAGES(2), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  twi_bus_events u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .ev_start (ev_start),
    .ev_stop  (ev_stop)
  );

  fsm_t              st;
  stage_t            stage;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [BIDX_W-1:0] bidx;
  logic [BYTE_W-1:0] addr_q;
  logic [DATA_W-1:0] wbuf;
  logic [DATA_W-1:0] txbuf;
  logic              pull_q;
  logic              we_q;
  logic              m_ack;

  assign in_idle = (st == S_IDLE);

  // Does a completed byte earn an acknowledge in this stage?
  function automatic logic byte_accept(input stage_t g, input logic [BYTE_W-1:0] b,
                                       input logic strap);
    case (g)
      G_ID:    return b == dev_id_byte(DEV_ADDR, strap, 1'b0);
      G_RID:   return b == dev_id_byte(DEV_ADDR, strap, 1'b1);
      default: return 1'b1;
    endcase
  endfunction

  // A repeated start is legal only as the first bit slot after the address ack
  logic rstart_ok;
  assign rstart_ok = (st == S_RX) && (stage == G_DATA) && (bidx == '0) && (bitcnt == 4'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      stage  <= G_ID;
      bitcnt <= '0;
      shreg  <= '0;
      bidx   <= '0;
      addr_q <= '0;
      wbuf   <= '0;
      txbuf  <= '0;
      pull_q <= 1'b0;
      we_q   <= 1'b0;
      m_ack  <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (ev_stop) begin
        st     <= S_IDLE;
        pull_q <= 1'b0;
      end else if (ev_start) begin
        bitcnt <= '0;
        pull_q <= 1'b0;
        if (st == S_IDLE) begin
          st    <= S_RX;
          stage <= G_ID;
        end else if (rstart_ok) begin
          st    <= S_RX;
          stage <= G_RID;
        end else begin
          st <= S_IDLE;
        end
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise && bitcnt < 4'd8) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (byte_accept(stage, shreg, strap_sel_i)) begin
                st     <= S_ACK;
                pull_q <= 1'b1;
                if (stage == G_ADDR) addr_q <= shreg;
                if (stage == G_DATA) wbuf <= (wbuf << BYTE_W) | DATA_W'(shreg);
              end else begin
                st <= S_IDLE;
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              pull_q <= 1'b0;
              bitcnt <= '0;
              case (stage)
                G_ID: begin
                  stage <= G_ADDR;
                  st    <= S_RX;
                end
                G_ADDR: begin
                  stage <= G_DATA;
                  bidx  <= '0;
                  st    <= S_RX;
                end
                G_DATA: begin
                  if (bidx == LAST_B) begin
                    we_q <= 1'b1;
                    st   <= S_IDLE;
                  end else begin
                    bidx <= bidx + 1'b1;
                    st   <= S_RX;
                  end
                end
                default: begin
                  txbuf  <= reg_rdata_i;
                  pull_q <= ~reg_rdata_i[DATA_W-1];
                  bidx   <= '0;
                  st     <= S_TX;
                end
              endcase
            end
          end
          S_TX: begin
            if (scl_fall) begin
              txbuf <= txbuf << 1;
              if (bitcnt == 4'd7) begin
                pull_q <= 1'b0;
                m_ack  <= 1'b0;
                st     <= S_MACK;
              end else begin
                pull_q <= ~txbuf[DATA_W-2];
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (m_ack && bidx != LAST_B) begin
                bidx   <= bidx + 1'b1;
                bitcnt <= '0;
                pull_q <= ~txbuf[DATA_W-1];
                st     <= S_TX;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o  = pull_q;
  assign reg_we_o    = we_q;
  assign reg_addr_o  = addr_q;
  assign reg_wdata_o = wbuf;

endmodule

// File: rtl/twi_reg_slave_chk.sv
module twi_reg_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_pull,
  input logic reg_we,
  input logic scl_sync,
  input logic start_ev,
  input logic stop_ev,
  input logic is_idle
);

  logic rst_seen_q;
  always_ff @(posedge clk) rst_seen_q <= !rst_n;

  // R1
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst_seen_q |-> (!sda_pull && !reg_we));

  // R10
  p_pull_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_sync);

  // R6
  p_we_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R6
  p_we_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(sda_pull));

  // R8
  p_stop_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> is_idle);

  // R4
  p_idle_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_idle |-> !sda_pull);

  // R3
  p_start_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && is_idle) |=> !is_idle);

endmodule

bind twi_reg_slave twi_reg_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_pull (sda_pull_o),
  .reg_we   (reg_we_o),
  .scl_sync (scl_s),
  .start_ev (ev_start),
  .stop_ev  (ev_stop),
  .is_idle  (in_idle)
);

// File: tb/tb_twi_reg_slave.sv
module tb_twi_reg_slave;

  localparam int H = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic        strap = 1'b0;
  wire         sda_bus;
  logic        sda_pull;
  logic [7:0]  raddr;
  logic [15:0] wdata;
  logic        we;
  logic [15:0] rdata;

  logic [15:0] bank   [256];
  logic [15:0] shadow [256];
  logic [23:0] wq[$];

  int   n_cmp = 0;
  int   n_bad = 0;
  logic exp_pull = 1'b0;
  logic settled = 1'b0;
  logic sampled;
  string cur_req = "R1";

  always #5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull;
  assign rdata   = bank[raddr];

  twi_reg_slave dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl),
    .sda_i       (sda_bus),
    .sda_pull_o  (sda_pull),
    .strap_sel_i (strap),
    .reg_addr_o  (raddr),
    .reg_wdata_o (wdata),
    .reg_we_o    (we),
    .reg_rdata_i (rdata)
  );

  always @(posedge clk) if (we) bank[raddr] <= wdata;

  task automatic check(input string req, input logic ok, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference pull compared on every settled clock (R10: steady through SCL high)
  always @(negedge clk) begin
    if (rst_n && settled) check(cur_req, sda_pull === exp_pull, sda_pull, exp_pull);
    if (rst_n && we) begin
      if (wq.size() == 0) check("R8", 1'b0, {raddr, wdata}, 0);
      else begin
        logic [23:0] e;
        e = wq.pop_front();
        check("R6", {raddr, wdata} === e, {raddr, wdata}, e);
      end
    end
  end

  task automatic slot(input logic mbit, input logic xp);
    settled = 1'b0; exp_pull = xp; sda_m = mbit;
    repeat (6) @(negedge clk);
    settled = 1'b1;
    repeat (H - 6) @(negedge clk);
    scl = 1'b1;
    repeat (H / 2) @(negedge clk);
    sampled = sda_bus;
    repeat (H / 2) @(negedge clk);
    scl = 1'b0;
  endtask

  task automatic bus_start();
    settled = 1'b0; exp_pull = 1'b0; sda_m = 1'b1;
    repeat (6) @(negedge clk);
    settled = 1'b1;
    repeat (H - 6) @(negedge clk);
    scl = 1'b1;
    repeat (H / 2) @(negedge clk);
    sda_m = 1'b0;
    repeat (H / 2) @(negedge clk);
    scl = 1'b0;
  endtask

  task automatic bus_stop();
    settled = 1'b0; exp_pull = 1'b0; sda_m = 1'b0;
    repeat (6) @(negedge clk);
    settled = 1'b1;
    repeat (H - 6) @(negedge clk);
    scl = 1'b1;
    repeat (H / 2) @(negedge clk);
    sda_m = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic wbyte(input logic [7:0] b, input logic ack, input string req);
    for (int i = 7; i >= 0; i--) slot(b[i], 1'b0);
    slot(1'b1, ack);
    check(req, sampled === !ack, sampled, !ack);
  endtask

  task automatic rbyte(input logic [7:0] e, input logic mack);
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      slot(1'b1, ~e[i]);
      got[i] = sampled;
    end
    check("R7", got === e, got, e);
    slot(!mack, 1'b0);
  endtask

  task automatic do_write(input logic [7:0] id, input logic [7:0] a, input logic [15:0] d,
                          input logic ok, input string req);
    cur_req = req;
    if (ok) begin
      wq.push_back({a, d});
      shadow[a] = d;
    end
    bus_start();
    wbyte(id, ok, req);
    wbyte(a, ok, req);
    wbyte(d[15:8], ok, req);
    wbyte(d[7:0], ok, req);
    bus_stop();
    check(req, wq.size() == 0, wq.size(), 0);
  endtask

  task automatic do_read(input logic [7:0] id, input logic [7:0] a);
    cur_req = "R7";
    bus_start();
    wbyte(id, 1'b1, "R7");
    wbyte(a, 1'b1, "R7");
    bus_start();
    wbyte(id | 8'h01, 1'b1, "R7");
    rbyte(shadow[a][15:8], 1'b1);
    rbyte(shadow[a][7:0], 1'b0);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      bank[i] = 16'(i * 3);
      shadow[i] = 16'(i * 3);
    end
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1", sda_pull === 1'b0, sda_pull, 0);
    check("R1", we === 1'b0, we, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", sda_pull === 1'b0, sda_pull, 0);
    scl = 1'b0;
    repeat (H) @(negedge clk);

    // R3/R6 write with strap low, then R7/R2 read, then R11 back-to-back
    strap = 1'b0;
    do_write(8'h34, 8'h05, 16'hA51E, 1'b1, "R6");
    do_read(8'h34, 8'h05);
    do_write(8'h34, 8'h06, 16'h00FF, 1'b1, "R11");
    do_read(8'h34, 8'h06);

    // R4: strap high, old ID ignored; R3: new ID accepted
    strap = 1'b1;
    do_write(8'h34, 8'h05, 16'h1111, 1'b0, "R4");
    do_write(8'h36, 8'h80, 16'h7F01, 1'b1, "R3");
    do_read(8'h36, 8'h80);
    do_read(8'h36, 8'h05);

    // R5: read bit in first ID byte
    do_write(8'h37, 8'h05, 16'h2222, 1'b0, "R5");
    // R5: write bit after repeated start
    cur_req = "R5";
    bus_start();
    wbyte(8'h36, 1'b1, "R5");
    wbyte(8'h05, 1'b1, "R5");
    bus_start();
    wbyte(8'h36, 1'b0, "R5");
    wbyte(8'h00, 1'b0, "R5");
    bus_stop();

    // R8: stop after the high data byte
    cur_req = "R8";
    bus_start();
    wbyte(8'h36, 1'b1, "R8");
    wbyte(8'h80, 1'b1, "R8");
    wbyte(8'h99, 1'b1, "R8");
    bus_stop();
    do_read(8'h36, 8'h80);

    // R9: start in the middle of the address byte
    cur_req = "R9";
    bus_start();
    wbyte(8'h36, 1'b1, "R9");
    slot(1'b0, 1'b0); slot(1'b1, 1'b0); slot(1'b0, 1'b0);
    bus_start();
    wbyte(8'h36, 1'b0, "R9");
    wbyte(8'h80, 1'b0, "R9");
    bus_stop();
    do_read(8'h36, 8'h80);

    // R1: reset while acknowledging
    cur_req = "R1";
    bus_start();
    for (int i = 7; i >= 0; i--) slot(8'h36 >> i, 1'b0);
    settled = 1'b0; sda_m = 1'b1;
    repeat (8) @(negedge clk);
    check("R3", sda_pull === 1'b1, sda_pull, 1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", sda_pull === 1'b0, sda_pull, 0);
    exp_pull = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    scl = 1'b1;
    repeat (H) @(negedge clk);
    scl = 1'b0;
    bus_stop();
    do_write(8'h36, 8'h07, 16'hBEEF, 1'b1, "R11");
    do_read(8'h36, 8'h07);

    repeat (20) @(negedge clk);
    check("R6", wq.size() == 0, wq.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule